// File: doc/BRIEF.md
# Shadow-Buffered Single-Channel PWM Generator

This block drives one pulse-width-modulated output from a free-running up-counter. The counter runs from zero to one less than a programmed period length and then returns to zero. A compare value fixes how many counts of each period the output spends in its asserted level, and a polarity field chooses whether that level is high or low. Software configures the block through a small word-addressed register port with byte enables and a one-cycle read latency.

Each of the two timing values, period and compare, has a live copy and a buffered copy. Software writes the live copies while the counter is stopped. While it runs, software writes the buffered copies instead. The block moves them into the live copies on the cycle the counter wraps, so the period in progress always completes with its old settings. An external restart input can force the counter back to zero unless the control register sets the sync selection to its disabled code.

Top module: `aux_pwm_gen`

## Requirements
- R1: After reset, every register reads as zero, the counter is stopped and `pwm_o` is low.
- R2: Accesses use word-aligned byte addresses. The live period is at 0x08, the live compare at 0x0C, the buffered period at 0x10 and the buffered compare at 0x14. The 16-bit control register sits in byte lanes 2–3 of the word at 0x28, with run at bit 4, sync selection at bits 7:6, PWM enable at bit 9 and polarity at bit 10; its other bits read as zero. A write changes only the byte lanes whose enable is set. Read data appears on `bus_rdata` on the clock edge after the request, and unmapped addresses read as zero.
- R3: While run is set, the counter steps by one each cycle and returns to 0 in the cycle after it reaches period−1; a period of 0 behaves like 1. While run is clear, the counter holds its value.
- R4: With polarity clear and PWM enable set, the output is high exactly while counter < compare. A compare of 0 gives a constant low output and a compare ≥ period a constant high output.
- R5: With polarity set, the output is the complement of the R4 level.
- R6: With PWM enable clear, the output is low regardless of the counter, compare or polarity.
- R7: A buffered period or compare write leaves the live values unchanged until the counter wraps. Both live values are then loaded from the buffered ones in that wrap cycle, so the period in progress ends with the old values.
- R8: A wrap loads the live values only if a buffered register was written since the previous load. Otherwise the live values are left as they are.
- R9: A write to a live register takes effect in the next cycle, even while the counter runs.
- R10: While running, a high `sync_i` sets the counter to 0 in the next cycle unless the sync selection equals 2'b11, in which case `sync_i` has no effect.
- R11: `pwm_o` is registered. Its level after a clock edge reflects the counter value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word-aligned byte address |
| bus_be | input | DATA_W/8 | Byte-lane write enables |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the request |
| sync_i | input | 1 | External counter restart |
| pwm_o | output | 1 | PWM output |

## Verification
A counter that is off by one, or that wraps at the wrong count, shifts the output edges. The exact-phase sweeps catch this within one period of the restart pulse. A buffered value that lands early cuts the running period short and changes the level one or two cycles before the boundary. A missing or repeated load shows up at the first wrap, both on the output and when the live registers are read back. A wrong mode or polarity flag inverts or kills the output on the cycle after the flag register changes.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    // Byte offsets of the register map.
    localparam logic [7:0] OFS_PER_LIVE = 8'h08;
    localparam logic [7:0] OFS_CMP_LIVE = 8'h0C;
    localparam logic [7:0] OFS_PER_BUF  = 8'h10;
    localparam logic [7:0] OFS_CMP_BUF  = 8'h14;
    localparam logic [7:0] OFS_CTRL     = 8'h2A;

    localparam int CTRL_W      = 16;
    localparam int CB_RUN      = 4;
    localparam int CB_SYNC_LO  = 6;
    localparam int CB_MODE     = 9;
    localparam int CB_POL      = 10;
    localparam logic [1:0] SYNC_OFF = 2'b11;

    typedef struct packed {
        logic       pol;
        logic       mode;
        logic [1:0] sync_sel;
        logic       run;
    } ctrl_t;

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] v;
        v = '0;
        v[CB_RUN]                  = c.run;
        v[CB_SYNC_LO+1:CB_SYNC_LO] = c.sync_sel;
        v[CB_MODE]                 = c.mode;
        v[CB_POL]                  = c.pol;
        return v;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] v);
        ctrl_t c;
        c.run      = v[CB_RUN];
        c.sync_sel = v[CB_SYNC_LO+1:CB_SYNC_LO];
        c.mode     = v[CB_MODE];
        c.pol      = v[CB_POL];
        return c;
    endfunction

endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
    import apwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W/8-1:0]   bus_be,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  wrap_i,
    output logic [DATA_W-1:0]     per_o,
    output logic [DATA_W-1:0]     cmp_o,
    output ctrl_t                 ctrl_o
);

    localparam int LANES   = DATA_W / 8;
    localparam int CTRL_SH = (int'(OFS_CTRL) % LANES) * 8;
    localparam logic [ADDR_W-1:0] A_PER_LIVE = ADDR_W'(OFS_PER_LIVE);
    localparam logic [ADDR_W-1:0] A_CMP_LIVE = ADDR_W'(OFS_CMP_LIVE);
    localparam logic [ADDR_W-1:0] A_PER_BUF  = ADDR_W'(OFS_PER_BUF);
    localparam logic [ADDR_W-1:0] A_CMP_BUF  = ADDR_W'(OFS_CMP_BUF);
    localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(OFS_CTRL) & ~ADDR_W'(LANES - 1);

    typedef struct packed {
        logic [DATA_W-1:0] per_live;
        logic [DATA_W-1:0] cmp_live;
        logic [DATA_W-1:0] per_buf;
        logic [DATA_W-1:0] cmp_buf;
        ctrl_t             ctrl;
        logic              pend;
        logic [DATA_W-1:0] rdata;
    } rf_t;

    rf_t  st_d, st_q;
    logic wr, rd, wr_per_live, wr_cmp_live, wr_buf;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [LANES-1:0]  be
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
        end
        return r;
    endfunction

    always_comb begin
        logic [DATA_W-1:0] cimg;
        st_d        = st_q;
        st_d.rdata  = '0;
        wr          = bus_en & bus_we;
        rd          = bus_en & ~bus_we;
        wr_per_live = wr & (bus_addr == A_PER_LIVE);
        wr_cmp_live = wr & (bus_addr == A_CMP_LIVE);
        wr_buf      = wr & ((bus_addr == A_PER_BUF) | (bus_addr == A_CMP_BUF));
        cimg        = DATA_W'(ctrl_pack(st_q.ctrl)) << CTRL_SH;

        // Boundary load of buffered values.
        if (wrap_i && st_q.pend) begin
            st_d.per_live = st_q.per_buf;
            st_d.cmp_live = st_q.cmp_buf;
        end

        if (wr) begin
            case (bus_addr)
                A_PER_LIVE: st_d.per_live = lane_merge(st_q.per_live, bus_wdata, bus_be);
                A_CMP_LIVE: st_d.cmp_live = lane_merge(st_q.cmp_live, bus_wdata, bus_be);
                A_PER_BUF:  st_d.per_buf  = lane_merge(st_q.per_buf,  bus_wdata, bus_be);
                A_CMP_BUF:  st_d.cmp_buf  = lane_merge(st_q.cmp_buf,  bus_wdata, bus_be);
                A_CTRL:     st_d.ctrl     = ctrl_unpack(CTRL_W'(
                                lane_merge(cimg, bus_wdata, bus_be) >> CTRL_SH));
                default: ;
            endcase
        end

        st_d.pend = (st_q.pend & ~wrap_i) | wr_buf;

        if (rd) begin
            case (bus_addr)
                A_PER_LIVE: st_d.rdata = st_q.per_live;
                A_CMP_LIVE: st_d.rdata = st_q.cmp_live;
                A_PER_BUF:  st_d.rdata = st_q.per_buf;
                A_CMP_BUF:  st_d.rdata = st_q.cmp_buf;
                A_CTRL:     st_d.rdata = cimg;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign per_o     = st_q.per_live;
    assign cmp_o     = st_q.cmp_live;
    assign ctrl_o    = st_q.ctrl;

    // R7: a pending buffered value reaches the live register at the wrap.
    assert_buf_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && st_q.pend && !wr_per_live) |=> (st_q.per_live == $past(st_q.per_buf)));

    // R8: without a pending load or a direct write the live period stays put.
    assert_no_stale_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wrap_i && st_q.pend) && !wr_per_live) |=> $stable(st_q.per_live));

    // R8: the pending flag drops at a wrap when no new buffered write arrives.
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !wr_buf) |=> !st_q.pend);

endmodule

// File: rtl/apwm_timebase.sv
module apwm_timebase
    import apwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [1:0]       sync_sel_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_t;

    tb_t              st_d, st_q;
    logic             sync_hit;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        st_d     = st_q;
        cnt_inc  = {1'b0, st_q.cnt} + 1'b1;
        sync_hit = run_i & sync_i & (sync_sel_i != SYNC_OFF);
        wrap_o   = run_i & ~sync_hit & (cnt_inc >= {1'b0, per_i});
        if (sync_hit || wrap_o) st_d.cnt = '0;
        else if (run_i)         st_d.cnt = cnt_inc[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R3: a stopped counter keeps its value.
    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.cnt));

    // R3: a running counter below the wrap point advances by one.
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !sync_i && ({1'b0, st_q.cnt} + 1'b1 < {1'b0, per_i}))
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R10: an accepted restart zeroes the counter.
    assert_sync_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && sync_i && sync_sel_i != SYNC_OFF) |=> (st_q.cnt == '0));

endmodule

// File: rtl/apwm_outstage.sv
module apwm_outstage #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             mode_i,
    input  logic             pol_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic pwm;
    } os_t;

    os_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwm = mode_i & ((cnt_i < cmp_i) ^ pol_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.pwm;

    // R6: PWM enable clear forces the output low.
    assert_forced_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> !pwm_o);

    // R4: zero compare with normal polarity never asserts the output.
    assert_zero_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !pol_i && cmp_i == '0) |=> !pwm_o);

    // R5: zero compare with inverted polarity holds the output high.
    assert_zero_cmp_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && pol_i && cmp_i == '0) |=> pwm_o);

endmodule

// File: rtl/aux_pwm_gen.sv
module aux_pwm_gen
    import apwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                sync_i,
    output logic                pwm_o
);

    logic [DATA_W-1:0] per_w, cmp_w, cnt_w;
    ctrl_t             ctrl_w;
    logic              wrap_w;

    apwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wrap_i    (wrap_w),
        .per_o     (per_w),
        .cmp_o     (cmp_w),
        .ctrl_o    (ctrl_w)
    );

    apwm_timebase #(.CNT_W(DATA_W)) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctrl_w.run),
        .sync_sel_i (ctrl_w.sync_sel),
        .sync_i     (sync_i),
        .per_i      (per_w),
        .cnt_o      (cnt_w),
        .wrap_o     (wrap_w)
    );

    apwm_outstage #(.CNT_W(DATA_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (cnt_w),
        .cmp_i  (cmp_w),
        .mode_i (ctrl_w.mode),
        .pol_i  (ctrl_w.pol),
        .pwm_o  (pwm_o)
    );

endmodule

// File: tb/tb_aux_pwm_gen.sv
module tb_aux_pwm_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we, sync_i;
    logic [7:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pwm_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int cur_p, cur_c;
    bit cur_pol;
    logic [31:0] rv;

    aux_pwm_gen dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sync_i(sync_i), .pwm_o(pwm_o)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk32(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input bit run, input bit mode, input bit pol,
                                              input logic [1:0] sel);
        logic [15:0] c;
        c = 16'(({15'd0, pol} << 10) | ({15'd0, mode} << 9) | ({14'd0, sel} << 6) | ({15'd0, run} << 4));
        return {c, 16'h0000};
    endfunction

    function automatic bit exp_lvl(input int j, input int p, input int c, input bit pol);
        return ((j % p) < c) ^ pol;
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        tick();
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        tick();
        d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic sync_pulse();
        sync_i = 1;
        tick();
        sync_i = 0;
    endtask

    // After edge E+1+j following a restart at edge E, the output shows level j.
    task automatic chk_run(input int start, input int n, input string req);
        for (int j = 0; j < n; j++) begin
            tick();
            chk32({31'd0, pwm_o}, {31'd0, exp_lvl(start + j, cur_p, cur_c, cur_pol)}, req);
        end
    endtask

    task automatic setup_run(input int p, input int c, input bit pol);
        cur_p = p; cur_c = c; cur_pol = pol;
        bus_wr(8'h28, 4'b1100, 32'h0);
        bus_wr(8'h08, 4'hF, p);
        bus_wr(8'h0C, 4'hF, c);
        bus_wr(8'h28, 4'b1100, ctrl_word(1, 1, pol, 2'b00));
        sync_pulse();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_en = 0; bus_we = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0; sync_i = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1: reset state
        chk32({31'd0, pwm_o}, 32'd0, "R1 pwm after reset");
        bus_rd(8'h08, rv); chk32(rv, 0, "R1 live period");
        bus_rd(8'h0C, rv); chk32(rv, 0, "R1 live compare");
        bus_rd(8'h10, rv); chk32(rv, 0, "R1 buffered period");
        bus_rd(8'h14, rv); chk32(rv, 0, "R1 buffered compare");
        bus_rd(8'h28, rv); chk32(rv, 0, "R1 control");
        repeat (5) tick();
        chk32({31'd0, pwm_o}, 32'd0, "R1 pwm stays low while stopped");

        // R2: byte lanes, control placement, unmapped address
        bus_wr(8'h08, 4'hF, 32'hAABBCCDD);
        bus_wr(8'h08, 4'b0101, 32'h11223344);
        bus_rd(8'h08, rv); chk32(rv, 32'hAA22CC44, "R2 byte-lane merge");
        bus_wr(8'h14, 4'b1000, 32'h5A000000);
        bus_rd(8'h14, rv); chk32(rv, 32'h5A000000, "R2 single top lane");
        bus_wr(8'h28, 4'hF, 32'h0640FFFF);
        bus_rd(8'h28, rv); chk32(rv, 32'h06400000, "R2 control in upper half");
        bus_wr(8'h28, 4'b1000, 32'h00000000);
        bus_rd(8'h28, rv); chk32(rv, 32'h00400000, "R2 control lane 3 only");
        bus_rd(8'h30, rv); chk32(rv, 0, "R2 unmapped reads zero");
        bus_wr(8'h28, 4'b1100, 32'h0);
        bus_wr(8'h14, 4'hF, 32'h0);

        // R3 R4 R5 R10 R11: exhaustive sweep of small period/compare/polarity
        for (int p = 1; p <= 6; p++) begin
            for (int c = 0; c <= 7; c++) begin
                for (int pl = 0; pl < 2; pl++) begin
                    setup_run(p, c, pl[0]);
                    if (pl != 0)          chk_run(0, 2 * p, "R5 inverted sweep");
                    else if (c == 0 || c >= p) chk_run(0, 2 * p, "R4 boundary sweep");
                    else                  chk_run(0, 2 * p, "R3 R11 R10 normal sweep");
                end
            end
        end

        // R10: sync ignored when selection is 2'b11
        setup_run(5, 2, 0);
        bus_wr(8'h28, 4'b1100, ctrl_word(1, 1, 0, 2'b11));
        chk32({31'd0, pwm_o}, {31'd0, exp_lvl(0, 5, 2, 0)}, "R10 after select write");
        sync_i = 1;
        tick();
        sync_i = 0;
        chk32({31'd0, pwm_o}, {31'd0, exp_lvl(1, 5, 2, 0)}, "R10 during ignored sync");
        chk_run(2, 10, "R10 phase kept through ignored sync");

        // R3: stopping holds the counter, restarting resumes
        setup_run(8, 4, 0);
        chk_run(0, 3, "R3 before stop");
        bus_wr(8'h28, 4'b1100, ctrl_word(0, 1, 0, 2'b00));
        chk32({31'd0, pwm_o}, {31'd0, exp_lvl(3, 8, 4, 0)}, "R3 stop edge");
        for (int k = 0; k < 16; k++) begin
            tick();
            chk32({31'd0, pwm_o}, {31'd0, exp_lvl(4, 8, 4, 0)}, "R3 held while stopped");
        end
        bus_wr(8'h28, 4'b1100, ctrl_word(1, 1, 0, 2'b00));
        chk_run(4, 8, "R3 resume from held count");

        // R7: buffered writes wait for the boundary
        setup_run(4, 2, 0);
        bus_en = 1; bus_we = 1; bus_be = 4'hF; bus_addr = 8'h10; bus_wdata = 6;
        tick();
        chk32({31'd0, pwm_o}, 32'd1, "R7 old period cycle 0");
        bus_addr = 8'h14; bus_wdata = 3;
        tick();
        chk32({31'd0, pwm_o}, 32'd1, "R7 old period cycle 1");
        bus_en = 0; bus_we = 0;
        tick();
        chk32({31'd0, pwm_o}, 32'd0, "R7 old compare still live");
        tick();
        chk32({31'd0, pwm_o}, 32'd0, "R7 old period completes");
        cur_p = 6; cur_c = 3;
        chk_run(0, 12, "R7 new values after boundary");
        bus_rd(8'h08, rv); chk32(rv, 6, "R7 live period loaded");
        bus_rd(8'h0C, rv); chk32(rv, 3, "R7 live compare loaded");

        // R9 and R8: direct live write applies at once and is not overwritten later
        bus_wr(8'h08, 4'hF, 3);
        bus_wr(8'h0C, 4'hF, 1);
        cur_p = 3; cur_c = 1;
        sync_pulse();
        chk_run(0, 12, "R9 live write while running");
        bus_rd(8'h08, rv); chk32(rv, 3, "R8 no reload without new buffered write");
        bus_rd(8'h0C, rv); chk32(rv, 1, "R8 compare not reloaded");

        // R6: PWM enable clear forces low, whatever the polarity
        bus_wr(8'h28, 4'b1100, ctrl_word(1, 0, 1, 2'b00));
        for (int k = 0; k < 10; k++) begin
            tick();
            chk32({31'd0, pwm_o}, 32'd0, "R6 disabled output low");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule